// File: doc/BRIEF.md
# Power-Up Reset Time-Out Sequencer

This block keeps a chip's internal reset asserted after power-on and lets it go only once a chain of waits has run out. The chain has three stages in a fixed order. First a power-up wait, measured in pulses of a slow timer tick. Then an oscillator settling wait of exactly 1024 cycles of the oscillator clock. Last a PLL lock wait, measured on the slow tick, that stands in for the real lock time. The oscillator and PLL stages each have an enable, and a disabled stage is passed over without spending a cycle.

The power-on pulse clears the block asynchronously and restarts the sequence from the beginning. The external reset pin is synchronised into the oscillator clock domain. While the pin is low the block parks in a holding state with every stage flag clear. When the pin is tied high, the power-on pulse alone starts the sequence.

States: `ST_HOLD` (waiting for the synchronised pin to be high), `ST_PWRUP` (power-up wait), `ST_OSCWAIT` (oscillator settling count), `ST_PLLWAIT` (PLL lock wait) and `ST_RUN` (reset released). The transitions are:
- HOLD→PWRUP when the pin is high.
- PWRUP→OSCWAIT, PLLWAIT or RUN on the last tick, whichever is the first enabled stage that follows.
- OSCWAIT→PLLWAIT or RUN on the 1024th cycle.
- PLLWAIT→RUN on the last tick.
- Any state→HOLD when the synchronised pin is low.
- Any state→HOLD when the power-on pulse arrives.

Top module: `rst_seq_timer`

## Requirements
- R1: The stages run in the order power-up, oscillator, PLL. `rst_out` falls only when the last enabled stage has expired, and it falls on the same clock edge.
- R2: With `ost_en`=1, the oscillator stage lasts exactly `OSC_CYCLES` (default 1024) clock cycles. `osc_done` rises on the edge that ends the stage.
- R3: The PLL stage lasts 2^`PLL_DIV_BITS` (default 8) slow ticks. It runs only when `pll_en`=1 at the moment the preceding stage ends.
- R4: With `ext_rst_n` held at 1, deasserting `por_in` alone starts the sequence. The state is `ST_PWRUP` by the third rising clock edge after `por_in` falls.
- R5: `rst_out`=1 and `ready`=0 in every state except `ST_RUN`, where `rst_out`=0 and `ready`=1.
- R6: The power-up stage ends on the `PWR_TICKS`-th clock edge (default 16) at which `slow_tick`=1 while in that stage. Ticks seen in other states do not advance it.
- R7: When the synchronised `ext_rst_n` is 0, the block enters `ST_HOLD` with `rst_out`=1 and all stage flags clear. Ticks in that state have no effect. The sequence restarts from the power-up stage after the pin returns to 1.
- R8: `por_in`=1 asynchronously forces `ST_HOLD` and clears all flags at any point. The sequence then restarts from the power-up stage.
- R9: A stage whose enable is 0 is skipped in zero cycles, and its done flag stays 0.
- R10: Each done flag (`pwr_done`, `osc_done`, `pll_done`) rises on the clock edge that ends its stage and stays set until a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_in | input | 1 | Power-on pulse, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| slow_tick | input | 1 | One-cycle pulse of the slow timer, synchronous to clk |
| ost_en | input | 1 | Enable for the oscillator settling stage |
| pll_en | input | 1 | Enable for the PLL lock stage |
| rst_out | output | 1 | Internal reset, active high |
| ready | output | 1 | High once reset has been released |
| pwr_done | output | 1 | Power-up stage expired |
| osc_done | output | 1 | Oscillator stage expired |
| pll_done | output | 1 | PLL stage expired |

## Verification
The hardest situation to reach from the ports is the oscillator stage's exact length. Its last cycle is not visible from outside until reset falls or `osc_done` rises. The bench handles this by driving the final power-up tick itself, so it knows the edge on which the stage begins. It then samples on 1023 and 1024 cycles after that edge. Restarts are reached the same way: the bench drives a power-on pulse or a low pin in the middle of a stage and counts ticks again from zero.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD    = 3'd0,
        ST_PWRUP   = 3'd1,
        ST_OSCWAIT = 3'd2,
        ST_PLLWAIT = 3'd3,
        ST_RUN     = 3'd4
    } seq_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge clr) begin
                if (clr) q <= '0;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or posedge clr) begin
                if (clr) q <= '0;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/rst_seq_cnt.sv
module rst_seq_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         clr_a,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or posedge clr_a) begin
        if (clr_a)     cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer
    import rst_seq_pkg::*;
#(
    parameter int PWR_TICKS    = 16,
    parameter int OSC_CYCLES   = 1024,
    parameter int PLL_DIV_BITS = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic por_in,
    input  logic ext_rst_n,
    input  logic slow_tick,
    input  logic ost_en,
    input  logic pll_en,
    output logic rst_out,
    output logic ready,
    output logic pwr_done,
    output logic osc_done,
    output logic pll_done
);
    localparam int PLL_TICKS = 1 << PLL_DIV_BITS;
    localparam int MAXC      = max3(PWR_TICKS, OSC_CYCLES, PLL_TICKS);
    localparam int CW        = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LIM_PWR = CW'(PWR_TICKS - 1);
    localparam logic [CW-1:0] LIM_OSC = CW'(OSC_CYCLES - 1);
    localparam logic [CW-1:0] LIM_PLL = CW'(PLL_TICKS - 1);

    seq_state_t    state, next_state;
    logic          pin_ok;
    logic          step, last, cnt_clr;
    logic [CW-1:0] cnt, lim;

    rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .clr (por_in),
        .din (ext_rst_n),
        .dout(pin_ok)
    );

    rst_seq_cnt #(.W(CW)) u_cnt (
        .clk  (clk),
        .clr_a(por_in),
        .clr  (cnt_clr),
        .step (step),
        .cnt  (cnt)
    );

    // Stage step source and terminal count.
    always_comb begin
        step = 1'b0;
        lim  = '0;
        unique case (state)
            ST_PWRUP:   begin step = slow_tick; lim = LIM_PWR; end
            ST_OSCWAIT: begin step = 1'b1;      lim = LIM_OSC; end
            ST_PLLWAIT: begin step = slow_tick; lim = LIM_PLL; end
            ST_HOLD, ST_RUN: begin step = 1'b0; lim = '0; end
        endcase
    end

    assign last = step && (cnt == lim);

    // Next-state logic.
    always_comb begin
        next_state = state;
        unique case (state)
            ST_HOLD:    if (pin_ok) next_state = ST_PWRUP;
            ST_PWRUP:   if (last) next_state = ost_en ? ST_OSCWAIT :
                                               (pll_en ? ST_PLLWAIT : ST_RUN);
            ST_OSCWAIT: if (last) next_state = pll_en ? ST_PLLWAIT : ST_RUN;
            ST_PLLWAIT: if (last) next_state = ST_RUN;
            ST_RUN:     next_state = ST_RUN;
        endcase
        if (!pin_ok) next_state = ST_HOLD;
    end

    assign cnt_clr = (next_state != state);

    // State register.
    always_ff @(posedge clk or posedge por_in) begin
        if (por_in) state <= ST_HOLD;
        else        state <= next_state;
    end

    // Stage flags.
    always_ff @(posedge clk or posedge por_in) begin
        if (por_in) begin
            pwr_done <= 1'b0;
            osc_done <= 1'b0;
            pll_done <= 1'b0;
        end else if (!pin_ok) begin
            pwr_done <= 1'b0;
            osc_done <= 1'b0;
            pll_done <= 1'b0;
        end else if (last) begin
            if (state == ST_PWRUP)   pwr_done <= 1'b1;
            if (state == ST_OSCWAIT) osc_done <= 1'b1;
            if (state == ST_PLLWAIT) pll_done <= 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        rst_out = 1'b1;
        ready   = 1'b0;
        unique case (state)
            ST_RUN: begin rst_out = 1'b0; ready = 1'b1; end
            ST_HOLD, ST_PWRUP, ST_OSCWAIT, ST_PLLWAIT: begin
                rst_out = 1'b1; ready = 1'b0;
            end
        endcase
    end

    // Independent dwell counter for the oscillator stage check.
    logic [CW-1:0] osc_dwell;
    always_ff @(posedge clk or posedge por_in) begin
        if (por_in)                  osc_dwell <= '0;
        else if (state != ST_OSCWAIT) osc_dwell <= '0;
        else                         osc_dwell <= osc_dwell + 1'b1;
    end

    assert_osc_len_R2: assert property (@(posedge clk) disable iff (por_in)
        (state == ST_OSCWAIT && next_state != ST_OSCWAIT && pin_ok)
            |-> (osc_dwell == LIM_OSC));

    assert_order_osc_R1: assert property (@(posedge clk) disable iff (por_in)
        (state == ST_OSCWAIT || state == ST_PLLWAIT) |-> pwr_done);

    assert_release_R1: assert property (@(posedge clk) disable iff (por_in)
        $fell(rst_out) |-> (pwr_done && !(ost_en && !osc_done && $past(state) == ST_OSCWAIT)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (por_in)
        !pin_ok |=> (state == ST_HOLD && !pwr_done && !osc_done && !pll_done));

    assert_flag_src_R10: assert property (@(posedge clk) disable iff (por_in)
        $rose(osc_done) |-> ($past(state) == ST_OSCWAIT));

    assert_pll_src_R3: assert property (@(posedge clk) disable iff (por_in)
        $rose(pll_done) |-> ($past(state) == ST_PLLWAIT));
endmodule

// File: tb/sim_rst_seq_timer.sv
module sim_rst_seq_timer;
    logic clk = 1'b0;
    logic por_in = 1'b1;
    logic ext_rst_n = 1'b1;
    logic slow_tick = 1'b0;
    logic ost_en = 1'b1;
    logic pll_en = 1'b1;
    logic rst_out, ready, pwr_done, osc_done, pll_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rst_seq_timer u0 (
        .clk(clk), .por_in(por_in), .ext_rst_n(ext_rst_n), .slow_tick(slow_tick),
        .ost_en(ost_en), .pll_en(pll_en), .rst_out(rst_out), .ready(ready),
        .pwr_done(pwr_done), .osc_done(osc_done), .pll_done(pll_done)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic do_por(input logic o, input logic p);
        @(negedge clk);
        ost_en = o; pll_en = p;
        por_in = 1'b1;
        cycles(3);
        por_in = 1'b0;
        cycles(4);
    endtask

    task automatic test_reset;
        @(negedge clk);
        por_in = 1'b1;
        cycles(2);
        chk(rst_out, 1'b1, "R5 reset rst_out");
        chk(ready, 1'b0, "R5 reset ready");
        chk(pwr_done | osc_done | pll_done, 1'b0, "R10 reset flags");
    endtask

    task automatic test_full;
        do_por(1'b1, 1'b1);
        ticks(15);
        chk(pwr_done, 1'b0, "R6 pwr before last tick");
        ticks(1);
        chk(pwr_done, 1'b1, "R6 pwr after last tick");
        chk(osc_done, 1'b0, "R1 osc not yet");
        chk(rst_out, 1'b1, "R1 still reset in osc");
        ticks(4);
        cycles(1023 - 8);
        chk(osc_done, 1'b0, "R2 osc at 1023 cycles");
        cycles(1);
        chk(osc_done, 1'b1, "R2 osc at 1024 cycles");
        chk(rst_out, 1'b1, "R3 reset held in pll");
        ticks(7);
        chk(pll_done, 1'b0, "R3 pll before 8 ticks");
        chk(rst_out, 1'b1, "R1 reset before last stage");
        ticks(1);
        chk(pll_done, 1'b1, "R3 pll after 8 ticks");
        chk(rst_out, 1'b0, "R1 release after pll");
        chk(ready, 1'b1, "R5 ready in run");
    endtask

    task automatic test_no_pll;
        do_por(1'b1, 1'b0);
        ticks(16);
        cycles(1023);
        chk(rst_out, 1'b1, "R2 no-pll reset at 1023");
        cycles(1);
        chk(ready, 1'b1, "R9 no-pll ready at 1024");
        chk(pll_done, 1'b0, "R9 pll flag clear when skipped");
    endtask

    task automatic test_skip_all;
        do_por(1'b0, 1'b0);
        ticks(16);
        chk(ready, 1'b1, "R9 ready right after pwr, R4 por-only start");
        chk(osc_done | pll_done, 1'b0, "R9 skipped flags clear");
    endtask

    task automatic test_pll_only;
        do_por(1'b0, 1'b1);
        ticks(16);
        chk(rst_out, 1'b1, "R9 osc skipped into pll");
        chk(osc_done, 1'b0, "R9 osc flag clear");
        ticks(8);
        chk(ready, 1'b1, "R3 pll-only ready");
    endtask

    task automatic test_pin_hold;
        do_por(1'b0, 1'b0);
        ticks(16);
        chk(ready, 1'b1, "R7 ready before pin low");
        @(negedge clk); ext_rst_n = 1'b0;
        cycles(4);
        chk(rst_out, 1'b1, "R7 reset with pin low");
        chk(pwr_done, 1'b0, "R7 flags cleared");
        ticks(20);
        chk(rst_out, 1'b1, "R7 ticks ignored while low");
        chk(pwr_done, 1'b0, "R6 ticks in hold ignored");
        ext_rst_n = 1'b1;
        cycles(4);
        ticks(15);
        chk(pwr_done, 1'b0, "R7 restart from zero");
        ticks(1);
        chk(ready, 1'b1, "R7 ready after restart");
    endtask

    task automatic test_por_abort;
        do_por(1'b1, 1'b1);
        ticks(16);
        cycles(100);
        @(negedge clk); por_in = 1'b1;
        #1;
        chk(rst_out, 1'b1, "R8 por forces reset");
        chk(pwr_done, 1'b0, "R8 por clears flags");
        @(negedge clk); por_in = 1'b0;
        cycles(4);
        ticks(15);
        chk(pwr_done, 1'b0, "R8 restart at first stage");
        ticks(1);
        chk(pwr_done, 1'b1, "R8 pwr after restart");
        chk(osc_done, 1'b0, "R8 osc from scratch");
    endtask

    initial begin
        test_reset();
        test_full();
        test_no_pll();
        test_skip_all();
        test_pll_only();
        test_pin_hold();
        test_por_abort();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule